// File: doc/BRIEF.md
# Dual-Channel Phase-Count PWM Generator

This block produces two independent pulse-width-modulated outputs. Each waveform is described by two 16-bit counts, one for the high phase and one for the low phase, so the period is their sum and the duty ratio follows from the split. Software writes the counts into one duty word per channel. A shared control word selects, for each channel, which of four timing sources drives it, how far that source is divided, whether the divided timebase is let through, and whether the channel runs.

The timing sources come in as single-cycle strobes in the system clock domain. The selected strobe is divided by (divider + 1), gated, and the result advances the channel's phase counter by one count. A duty word written while a channel runs is picked up only when the current period ends, so no period is ever cut short or mixed. A zero low count still makes the output drop for one count per period, and a zero high count keeps the output low.

Top module: `dual_phase_pwm`

## Requirements
- R1: After reset every register reads zero and both outputs are low; each register reads back the last value written to it (word address 0 is the channel A duty word, 1 the channel B duty word, 2 the control word).
- R2: A duty word holds the low-phase count in bits [15:0] and the high-phase count in bits [31:16]; each period the output is high for the high count and then low for the low count.
- R3: The prescaler divides the selected source by (divider + 1); the 7-bit divider sits at control bits [14:8] for channel A and [22:16] for channel B.
- R4: The 2-bit source select sits at control bits [5:4] for channel A and [7:6] for channel B and picks one of the four source strobes by index; a source that never strobes leaves the output low.
- R5: A low count of zero gives a low phase of exactly one count; with the high count at 0xFFFF the output is high for 0xFFFF counts and low for one.
- R6: A high count of zero keeps the output low for the whole period.
- R7: A duty word written while a channel runs takes effect only at the start of the next period.
- R8: The run enable (control bit 0 for A, bit 1 for B) and the clock gate (bit 15 for A, bit 23 for B) must both be set for a channel to run; otherwise its output is held low and its counters are cleared, so a restart begins with a full high phase.
- R9: The two channels run independently; settings of one do not change the waveform of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_i | input | 4 | Timing source strobes, one bit per source |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i |
| pwm_o | output | 2 | PWM outputs, bit 0 channel A, bit 1 channel B |

## Verification
The assertions watch, on every cycle, that a stopped channel drives its output low on the next cycle, that the output never moves without a divided tick, that divided ticks are spaced when the divider is non-zero, that the high-phase count stays below the captured high count, and that the captured duty word cannot change inside a high phase. Exact phase lengths in cycles for each divider, source and count pattern, the one-count low pulse at full high count, the deferred duty update, the restart after stop and the independence of the channels can only be shown by the bench's scenarios, which measure the waveforms at the pins.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    localparam int NUM_CH  = 2;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 7;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int REG_W   = 2 * CNT_W;
    localparam int ADDR_W  = 2;
    localparam int CTRL_IDX = NUM_CH;

    // Per-channel field placement inside the shared control word
    localparam int SEL_BASE  = 4;
    localparam int DIV_BASE  = 8;
    localparam int GATE_BASE = 15;
    localparam int CH_STRIDE = 8;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } duty_t;

    typedef struct packed {
        logic             en;
        logic             gate;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
    } ch_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

    function automatic int en_pos(int ch);
        return ch;
    endfunction

    function automatic int sel_pos(int ch);
        return SEL_BASE + SEL_W * ch;
    endfunction

    function automatic int div_pos(int ch);
        return DIV_BASE + CH_STRIDE * ch;
    endfunction

    function automatic int gate_pos(int ch);
        return GATE_BASE + CH_STRIDE * ch;
    endfunction

    function automatic ch_cfg_t decode_cfg(logic [REG_W-1:0] ctrl, int ch);
        ch_cfg_t          c;
        logic [REG_W-1:0] s;
        c.en   = ctrl[en_pos(ch)];
        c.gate = ctrl[gate_pos(ch)];
        s      = ctrl >> sel_pos(ch);
        c.sel  = s[SEL_W-1:0];
        s      = ctrl >> div_pos(ch);
        c.div  = s[DIV_W-1:0];
        return c;
    endfunction

    // Last count index of the low phase; a zero count still lasts one count
    function automatic logic [CNT_W-1:0] low_last(logic [CNT_W-1:0] lo);
        return (lo == '0) ? '0 : lo - 1'b1;
    endfunction

endpackage

// File: rtl/dpwm_regs.sv
module dpwm_regs
    import dpwm_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int AW   = ADDR_W,
    parameter int DW   = REG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    output duty_t [N_CH-1:0]      duty_o,
    output logic [DW-1:0]         ctrl_o
);

    localparam int CIDX = N_CH;

    duty_t [N_CH-1:0] duty_q;
    logic  [DW-1:0]   ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en_i) begin
            for (int i = 0; i < N_CH; i++) begin
                if (addr_i == AW'(i)) begin
                    duty_q[i] <= duty_t'(wdata_i);
                end
            end
            if (addr_i == AW'(CIDX)) begin
                ctrl_q <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (addr_i == AW'(i)) begin
                rdata_o = duty_q[i];
            end
        end
        if (addr_i == AW'(CIDX)) begin
            rdata_o = ctrl_q;
        end
    end

    assign duty_o = duty_q;
    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/dpwm_clk_path.sv
module dpwm_clk_path
    import dpwm_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int DVW   = DIV_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_i,
    input  logic [N_SRC-1:0]         src_tick_i,
    input  logic [$clog2(N_SRC)-1:0] sel_i,
    input  logic [DVW-1:0]           div_i,
    output logic                     tick_o
);

    logic [DVW-1:0] pcnt_q;
    logic           src_hit;
    logic           wrap;

    assign src_hit = src_tick_i[sel_i];
    assign wrap    = (pcnt_q >= div_i);
    assign tick_o  = run_i && src_hit && wrap;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pcnt_q <= '0;
        end else if (src_hit) begin
            pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dpwm_phase_gen.sv
module dpwm_phase_gen
    import dpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             tick_i,
    input  duty_t            duty_i,
    output logic             pwm_o,
    output logic             high_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] hi_sh_o
);

    duty_t            sh_q;
    phase_e           st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             hi_done;

    assign hi_done = (cnt_q == sh_q.hi - 1'b1);
    assign restart = (st_q == PH_IDLE) ||
                     ((st_q == PH_LOW) && (cnt_q >= low_last(sh_q.lo)));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (tick_i) begin
            if (restart) begin
                sh_q  <= duty_i;
                cnt_q <= '0;
                st_q  <= (duty_i.hi != '0) ? PH_HIGH : PH_LOW;
            end else if (st_q == PH_HIGH && hi_done) begin
                st_q  <= PH_LOW;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pwm_o   = (st_q == PH_HIGH);
    assign high_o  = (st_q == PH_HIGH);
    assign cnt_o   = cnt_q;
    assign hi_sh_o = sh_q.hi;

endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
    import dpwm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_tick_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    output logic [NUM_CH-1:0]  pwm_o
);

    duty_t [NUM_CH-1:0]            duty_w;
    logic  [REG_W-1:0]             ctrl_w;
    logic  [NUM_CH-1:0]            run_w;
    logic  [NUM_CH-1:0]            tick_w;
    logic  [NUM_CH-1:0]            high_w;
    logic  [NUM_CH-1:0]            div_nz_w;
    logic  [NUM_CH-1:0][CNT_W-1:0] cnt_w;
    logic  [NUM_CH-1:0][CNT_W-1:0] hi_sh_w;

    dpwm_regs #(
        .N_CH (NUM_CH),
        .AW   (ADDR_W),
        .DW   (REG_W)
    ) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .duty_o  (duty_w),
        .ctrl_o  (ctrl_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ch_cfg_t cfg;
        assign cfg         = decode_cfg(ctrl_w, c);
        assign run_w[c]    = cfg.en && cfg.gate;
        assign div_nz_w[c] = (cfg.div != '0);

        dpwm_clk_path #(
            .N_SRC (NUM_SRC),
            .DVW   (DIV_W)
        ) clk_path_i (
            .clk        (clk),
            .rst        (rst),
            .run_i      (run_w[c]),
            .src_tick_i (src_tick_i),
            .sel_i      (cfg.sel),
            .div_i      (cfg.div),
            .tick_o     (tick_w[c])
        );

        dpwm_phase_gen phase_i (
            .clk     (clk),
            .rst     (rst),
            .run_i   (run_w[c]),
            .tick_i  (tick_w[c]),
            .duty_i  (duty_w[c]),
            .pwm_o   (pwm_o[c]),
            .high_o  (high_w[c]),
            .cnt_o   (cnt_w[c]),
            .hi_sh_o (hi_sh_w[c])
        );
    end

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
    import dpwm_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic [NUM_CH-1:0]               pwm,
    input logic [NUM_CH-1:0]               run,
    input logic [NUM_CH-1:0]               tick,
    input logic [NUM_CH-1:0]               high,
    input logic [NUM_CH-1:0]               div_nz,
    input logic [NUM_CH-1:0][CNT_W-1:0]    cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0]    hi_sh
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
            !run[c] |=> !pwm[c]); // R8

        AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
            (run[c] && !tick[c]) |=> $stable(pwm[c])); // R3

        AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
            (tick[c] && div_nz[c]) |=> (!tick[c] || !div_nz[c])); // R3

        AST_HIGH_NONZERO: assert property (@(posedge clk) disable iff (rst)
            high[c] |-> (hi_sh[c] != '0)); // R6

        AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
            high[c] |-> (cnt[c] < hi_sh[c])); // R2

        AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
            (high[c] && $past(high[c])) |-> $stable(hi_sh[c])); // R7
    end

endmodule

bind dual_phase_pwm dpwm_checker chk_i (
    .clk    (clk),
    .rst    (rst),
    .pwm    (pwm_o),
    .run    (run_w),
    .tick   (tick_w),
    .high   (high_w),
    .div_nz (div_nz_w),
    .cnt    (cnt_w),
    .hi_sh  (hi_sh_w)
);

// File: tb/dual_phase_pwm_tb_top.sv
`timescale 1ns/1ps
module dual_phase_pwm_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  src = 4'b0001;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  pwm;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    dual_phase_pwm dut_i (
        .clk        (clk),
        .rst        (rst),
        .src_tick_i (src),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .pwm_o      (pwm)
    );

    // Source 0 every cycle, 1 every 2nd, 2 every 3rd, 3 never
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            src[0] = 1'b1;
            src[1] = (cyc % 2 == 0);
            src[2] = (cyc % 3 == 0);
            src[3] = 1'b0;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(bit ena, bit gta, int sela, int diva,
                                            bit enb, bit gtb, int selb, int divb);
        logic [31:0] w = '0;
        w[0]     = ena;
        w[1]     = enb;
        w[5:4]   = sela[1:0];
        w[7:6]   = selb[1:0];
        w[14:8]  = diva[6:0];
        w[15]    = gta;
        w[22:16] = divb[6:0];
        w[23]    = gtb;
        return w;
    endfunction

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic measure(int ch, output int h, output int l);
        @(negedge clk);
        while (pwm[ch]) @(negedge clk);
        while (!pwm[ch]) @(negedge clk);
        h = 0;
        while (pwm[ch]) begin h++; @(negedge clk); end
        l = 0;
        while (!pwm[ch]) begin l++; @(negedge clk); end
    endtask

    task automatic count_high(int ch, int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm[ch]) h++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 3; i++) begin
            rd(2'(i), d);
            check("R1", "reset register value", int'(d), 0);
        end
        check("R1", "reset outputs", int'(pwm), 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(2'd2, 32'h00A5_5A00);
        rd(2'd2, d);
        check("R1", "control readback", int'(d), int'(32'h00A5_5A00));
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h1234_5678);
        rd(2'd1, d);
        check("R1", "duty B readback", int'(d), int'(32'h1234_5678));
        rd(2'd0, d);
        check("R1", "duty A untouched", int'(d), 0);
    endtask

    task automatic t_basic();
        int h, l;
        wr(2'd0, 32'h0003_0005);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        measure(0, h, l);
        check("R2", "high 3", h, 3);
        check("R2", "low 5", l, 5);
        wr(2'd0, 32'h0007_0001);
        measure(0, h, l);
        check("R2", "high 7", h, 7);
        check("R2", "low 1", l, 1);
    endtask

    task automatic t_prescale();
        int h, l;
        wr(2'd0, 32'h0002_0004);
        wr(2'd1, 32'h0002_0002);
        wr(2'd2, mk_ctrl(1, 1, 0, 2, 1, 1, 0, 1));
        measure(0, h, l);
        check("R3", "A div 2 high", h, 6);
        check("R3", "A div 2 low", l, 12);
        measure(1, h, l);
        check("R3", "B div 1 high", h, 4);
        check("R3", "B div 1 low", l, 4);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_select();
        int h, l;
        wr(2'd0, 32'h0002_0003);
        wr(2'd1, 32'h0001_0002);
        wr(2'd2, mk_ctrl(1, 1, 1, 1, 1, 1, 2, 0));
        measure(0, h, l);
        check("R4", "A source 1 high", h, 8);
        check("R4", "A source 1 low", l, 12);
        measure(1, h, l);
        check("R4", "B source 2 high", h, 3);
        check("R4", "B source 2 low", l, 6);
        wr(2'd2, mk_ctrl(1, 1, 3, 0, 0, 0, 0, 0));
        count_high(0, 40, h);
        check("R4", "silent source high samples", h, 0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_low_zero();
        int h, l;
        wr(2'd0, 32'h0004_0000);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        measure(0, h, l);
        check("R5", "high 4 low 0: high", h, 4);
        check("R5", "high 4 low 0: low", l, 1);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'hFFFF_0000);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        measure(0, h, l);
        check("R5", "full high count: high", h, 65535);
        check("R5", "full high count: low", l, 1);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_high_zero();
        int h;
        wr(2'd0, 32'h0000_0005);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        count_high(0, 60, h);
        check("R6", "zero high count samples", h, 0);
        wr(2'd0, 32'h0000_0000);
        count_high(0, 20, h);
        check("R6", "both counts zero samples", h, 0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_update();
        int h, l;
        wr(2'd0, 32'h0003_0005);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        while (pwm[0]) @(negedge clk);
        while (!pwm[0]) @(negedge clk);
        wr_en = 1'b1; addr = 2'd0; wdata = 32'h0006_0002;
        h = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (pwm[0]) begin h++; @(negedge clk); end
        l = 0;
        while (!pwm[0]) begin l++; @(negedge clk); end
        check("R7", "current period high kept", h, 3);
        check("R7", "current period low kept", l, 5);
        measure(0, h, l);
        check("R7", "next period high", h, 6);
        check("R7", "next period low", l, 2);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_stop();
        int h, l;
        wr(2'd0, 32'h0003_0005);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        measure(0, h, l);
        wr(2'd2, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        count_high(0, 30, h);
        check("R8", "gate clear high samples", h, 0);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 0, 0, 0, 0));
        measure(0, h, l);
        check("R8", "restart after gate high", h, 3);
        check("R8", "restart after gate low", l, 5);
        wr(2'd2, mk_ctrl(0, 1, 0, 0, 0, 0, 0, 0));
        @(negedge clk);
        count_high(0, 30, h);
        check("R8", "enable clear high samples", h, 0);
        wr(2'd2, 32'h0);
    endtask

    task automatic t_indep();
        int h, l;
        wr(2'd0, 32'h0003_0005);
        wr(2'd1, 32'h0002_0007);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 1, 1, 0, 0));
        measure(0, h, l);
        check("R9", "A high with B running", h, 3);
        check("R9", "A low with B running", l, 5);
        measure(1, h, l);
        check("R9", "B high", h, 2);
        check("R9", "B low", l, 7);
        wr(2'd1, 32'h0009_0001);
        wr(2'd2, mk_ctrl(1, 1, 0, 0, 1, 1, 0, 3));
        measure(0, h, l);
        check("R9", "A high after B change", h, 3);
        check("R9", "A low after B change", l, 5);
        wr(2'd2, 32'h0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_basic();
        t_prescale();
        t_select();
        t_high_zero();
        t_update();
        t_stop();
        t_indep();
        t_low_zero();
        finish_run();
    end

endmodule